// File: doc/BRIEF.md
# Rotate-Through-Carry and Bit-Test Flag Unit

This unit sits in the execute stage of an 8-bit processor. It carries out a left rotate of one operand byte through the carry flag and keeps the four condition flags: zero (Z), subtract (N), half-carry (H) and carry (C). There are two rotate variants. The short accumulator form always clears Z. The prefixed register form sets Z from the 8-bit result. The unit also runs a single-bit test, which writes the flags and leaves the result byte alone.

A caller drives an operand, an operation code, a bit index and a one-cycle commit strobe. An accepted operation updates the result and flag registers on that clock edge. A small sequencer then holds `busy` high for the remaining cycles of the operation's cost. That is 4 cycles in total for the accumulator rotate and 8 for the prefixed rotate and the bit test. The sequencer has two states, named in the RTL `ST_IDLE` and `ST_WAIT`. `ST_IDLE` moves to `ST_WAIT` on an accepted commit. `ST_WAIT` counts down and returns to `ST_IDLE` when its counter reaches zero. A commit seen in `ST_WAIT` is dropped.

Top module: `rlc_flag_unit`

## Requirements
- R1: An accepted rotate (op code 0 = accumulator rotate, op code 1 = prefixed rotate) writes result = {operand[6:0], previous C}.
- R2: An accepted rotate of either kind sets C to operand bit 7 as it was before the rotate.
- R3: Both rotate kinds clear N and H. The `flags` port is laid out as Z in bit 7, N in bit 6, H in bit 5, C in bit 4, and zero in bits 3..0.
- R4: The accumulator rotate (op 0) clears Z even when the rotated byte is zero.
- R5: The prefixed rotate (op 1) sets Z exactly when the 8-bit result is zero.
- R6: An accepted bit test (op code 2) sets Z to the inverse of operand[bit_sel], clears N, sets H, and leaves C and the result byte unchanged.
- R7: Result and flags change only on a clock edge where the commit is accepted. They hold while commit is low and when op code 3 (reserved) is committed, and op code 3 does not raise busy.
- R8: A synchronous active-high reset clears result, all flags and busy to 0.
- R9: After an accepted accumulator rotate, busy is high for the next 3 cycles. After a prefixed rotate or bit test, it is high for 7 cycles. A commit while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| commit | input | 1 | Strobe requesting the operation on the current inputs |
| op | input | 2 | Operation: 0 accumulator rotate, 1 prefixed rotate, 2 bit test, 3 reserved |
| bit_sel | input | 3 | Bit index for the bit test |
| operand | input | 8 | Operand byte |
| result | output | 8 | Registered result byte |
| flags | output | 8 | Registered flags {Z,N,H,C,4'b0} |
| busy | output | 1 | High while the accepted operation's cycle cost runs out |

## Verification
The bench checks the accumulator rotate on a byte that rotates to zero: a design that took Z from the result would set Z there. It runs chains of rotates in which the carry shifted out of one operation must come back in as bit 0 of the next, which catches stale-carry and wrong-bit-order faults. Bit tests are run with C set, and the bench checks that C and the result byte survive, since a design that shared the rotate write path would disturb them. It also measures the busy window for each operation cost, and it commits during busy, with reserved codes and with commit low, to expose any design that lets a blocked or invalid request change state.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    typedef enum logic [1:0] {
        OP_ACC_ROT  = 2'd0,
        OP_PFX_ROT  = 2'd1,
        OP_BIT_TEST = 2'd2,
        OP_RSVD     = 2'd3
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/rlc_alu.sv
module rlc_alu
    import rlc_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e                    op,
    input  logic [$clog2(DW)-1:0]  bit_sel,
    input  logic [DW-1:0]          operand,
    input  flags_t                 cur_flags,
    output logic [DW-1:0]          res_nxt,
    output flags_t                 flags_nxt,
    output logic                   wr_res
);

    logic [DW-1:0] rotated;

    always_comb begin
        rotated = {operand[DW-2:0], cur_flags.c};
    end

    always_comb begin
        res_nxt   = rotated;
        flags_nxt = cur_flags;
        wr_res    = 1'b0;
        unique case (op)
            OP_ACC_ROT: begin
                wr_res      = 1'b1;
                flags_nxt.z = 1'b0;
                flags_nxt.n = 1'b0;
                flags_nxt.h = 1'b0;
                flags_nxt.c = operand[DW-1];
            end
            OP_PFX_ROT: begin
                wr_res      = 1'b1;
                flags_nxt.z = (rotated == '0);
                flags_nxt.n = 1'b0;
                flags_nxt.h = 1'b0;
                flags_nxt.c = operand[DW-1];
            end
            OP_BIT_TEST: begin
                flags_nxt.z = ~operand[bit_sel];
                flags_nxt.n = 1'b0;
                flags_nxt.h = 1'b1;
            end
            OP_RSVD: begin
                flags_nxt = cur_flags;
            end
            default: begin
                flags_nxt = cur_flags;
            end
        endcase
    end

endmodule

// File: rtl/rlc_seq.sv
module rlc_seq
    import rlc_pkg::*;
#(
    parameter int ACC_CYCLES = 4,
    parameter int PFX_CYCLES = 8,
    parameter int BIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  op_e  op,
    output logic accept,
    output logic busy
);

    localparam int MAXC_A = (ACC_CYCLES > PFX_CYCLES) ? ACC_CYCLES : PFX_CYCLES;
    localparam int MAXC   = (MAXC_A > BIT_CYCLES) ? MAXC_A : BIT_CYCLES;
    localparam int CW     = (MAXC > 2) ? $clog2(MAXC) : 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

    st_e           state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (op)
            OP_ACC_ROT:  load_val = CW'(ACC_CYCLES - 2);
            OP_PFX_ROT:  load_val = CW'(PFX_CYCLES - 2);
            OP_BIT_TEST: load_val = CW'(BIT_CYCLES - 2);
            default:     load_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        accept    = 1'b0;
        busy      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (commit && op != OP_RSVD) begin
                    accept    = 1'b1;
                    state_nxt = ST_WAIT;
                    cnt_nxt   = load_val;
                end
            end
            ST_WAIT: begin
                busy = 1'b1;
                if (cnt == '0) begin
                    state_nxt = ST_IDLE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // R9: the wait countdown stays within the largest cost
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (int'(cnt) <= MAXC - 2));

    // R9: no new request is accepted in the wait state
    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cnt) || (cnt == $past(cnt) - 1'b1) || (state == ST_IDLE));

endmodule

// File: rtl/rlc_state_reg.sv
module rlc_state_reg
    import rlc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          wr_res,
    input  logic [DW-1:0] res_nxt,
    input  flags_t        flags_nxt,
    output logic [DW-1:0] result_q,
    output flags_t        flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (accept) begin
            flags_q <= flags_nxt;
            if (wr_res) begin
                result_q <= res_nxt;
            end
        end
    end

    // R7: without an accepted request the registers hold
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(flags_q) && $stable(result_q));

endmodule

// File: rtl/rlc_flag_unit.sv
module rlc_flag_unit
    import rlc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int ACC_CYCLES = 4,
    parameter int PFX_CYCLES = 8,
    parameter int BIT_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  logic [1:0]            op,
    input  logic [$clog2(DW)-1:0] bit_sel,
    input  logic [DW-1:0]         operand,
    output logic [DW-1:0]         result,
    output logic [7:0]            flags,
    output logic                  busy
);

    op_e           op_t;
    logic          accept;
    logic          wr_res;
    logic [DW-1:0] res_nxt;
    flags_t        flags_nxt;
    flags_t        flags_q;

    always_comb op_t = op_e'(op);

    rlc_seq #(
        .ACC_CYCLES (ACC_CYCLES),
        .PFX_CYCLES (PFX_CYCLES),
        .BIT_CYCLES (BIT_CYCLES)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .op     (op_t),
        .accept (accept),
        .busy   (busy)
    );

    rlc_alu #(.DW(DW)) u_alu (
        .op        (op_t),
        .bit_sel   (bit_sel),
        .operand   (operand),
        .cur_flags (flags_q),
        .res_nxt   (res_nxt),
        .flags_nxt (flags_nxt),
        .wr_res    (wr_res)
    );

    rlc_state_reg #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .wr_res    (wr_res),
        .res_nxt   (res_nxt),
        .flags_nxt (flags_nxt),
        .result_q  (result),
        .flags_q   (flags_q)
    );

    always_comb flags = {flags_q.z, flags_q.n, flags_q.h, flags_q.c, 4'b0000};

    // R4: accumulator rotate never leaves Z set
    p_acc_z_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && op_t == OP_ACC_ROT) |=> !flags[7]);

    // R2: carry comes from the pre-rotate top bit
    p_carry_b7_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && (op_t == OP_ACC_ROT || op_t == OP_PFX_ROT)) |=> flags[4] == $past(operand[DW-1]));

    // R3: rotates clear N and H
    p_nh_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && (op_t == OP_ACC_ROT || op_t == OP_PFX_ROT)) |=> !flags[6] && !flags[5]);

    // R6: bit test keeps C and result, sets H
    p_bit_keep_c_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && op_t == OP_BIT_TEST) |=> flags[5] && $stable(flags[4]) && $stable(result));

    // R9: a commit during busy changes nothing
    p_busy_block_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(flags) && $stable(result));

endmodule

// File: tb/rlc_flag_unit_bench.sv
`timescale 1ns/1ps
module rlc_flag_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       commit = 1'b0;
    logic [1:0] op = 2'd0;
    logic [2:0] bit_sel = 3'd0;
    logic [7:0] operand = 8'h00;
    logic [7:0] result;
    logic [7:0] flags;
    logic       busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] m_res;
    logic       m_z, m_n, m_h, m_c;

    always #2.5 clk = ~clk;

    rlc_flag_unit u_rlc_flag_unit (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .op      (op),
        .bit_sel (bit_sel),
        .operand (operand),
        .result  (result),
        .flags   (flags),
        .busy    (busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_flags();
        return {m_z, m_n, m_h, m_c, 4'b0000};
    endfunction

    task automatic check_state(input string req);
        check({req, " result"}, result, m_res);
        check({req, " flags"}, flags, m_flags());
    endtask

    task automatic model(input logic [1:0] o, input logic [2:0] b, input logic [7:0] d);
        logic [7:0] r;
        r = {d[6:0], m_c};
        case (o)
            2'd0: begin m_res = r; m_z = 1'b0; m_n = 1'b0; m_h = 1'b0; m_c = d[7]; end
            2'd1: begin m_res = r; m_z = (r == 8'h00); m_n = 1'b0; m_h = 1'b0; m_c = d[7]; end
            2'd2: begin m_z = ~d[b]; m_n = 1'b0; m_h = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] o, input logic [2:0] b, input logic [7:0] d);
        @(negedge clk);
        op = o; bit_sel = b; operand = d; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        model(o, b, d);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_res = 8'h00; m_z = 0; m_n = 0; m_h = 0; m_c = 0;
        check("R8 reset result", result, 8'h00);
        check("R8 reset flags", flags, 8'h00);
        check("R8 reset busy", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_acc_rotate();
        issue(2'd0, 3'd0, 8'h85); check_state("R1 R2 R3 acc 85");
        check("R1 acc 85 value", result, 8'h0A);
        wait_idle();
        issue(2'd0, 3'd0, 8'h00); check_state("R1 acc carry-in");
        check("R1 acc carry-in value", result, 8'h01);
        wait_idle();
        issue(2'd0, 3'd0, 8'h80); check_state("R4 acc zero result");
        check("R4 Z clear", {7'd0, flags[7]}, 8'h00);
        wait_idle();
    endtask

    task automatic t_pfx_rotate();
        issue(2'd1, 3'd0, 8'h80); check_state("R5 pfx carry-in nonzero");
        wait_idle();
        issue(2'd1, 3'd0, 8'h00); check_state("R5 pfx 00 with C");
        wait_idle();
        issue(2'd1, 3'd0, 8'h80); check_state("R5 pfx zero result");
        check("R5 Z set", {7'd0, flags[7]}, 8'h01);
        wait_idle();
        issue(2'd1, 3'd0, 8'hC3); check_state("R2 R3 pfx C3");
        wait_idle();
    endtask

    task automatic t_bit_test();
        issue(2'd0, 3'd0, 8'hF0); wait_idle();
        issue(2'd2, 3'd7, 8'h7F); check_state("R6 bit7 clear");
        check("R6 C kept", {7'd0, flags[4]}, 8'h01);
        wait_idle();
        issue(2'd2, 3'd3, 8'h08); check_state("R6 bit3 set");
        wait_idle();
    endtask

    task automatic t_busy_window();
        int n;
        issue(2'd0, 3'd0, 8'h11); n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R9 acc busy cycles", 8'(n), 8'd3);
        issue(2'd1, 3'd0, 8'h22); n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R9 pfx busy cycles", 8'(n), 8'd7);
        issue(2'd2, 3'd1, 8'h22); n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R9 bit busy cycles", 8'(n), 8'd7);
    endtask

    task automatic t_blocked();
        issue(2'd1, 3'd0, 8'h40);
        op = 2'd0; operand = 8'hFF; commit = 1'b1;
        @(negedge clk);
        op = 2'd2; bit_sel = 3'd0; operand = 8'h00;
        @(negedge clk);
        commit = 1'b0;
        check_state("R9 commit during busy");
        wait_idle();
        check_state("R9 after busy");
    endtask

    task automatic t_ignored();
        @(negedge clk);
        op = 2'd1; operand = 8'hFF; commit = 1'b0;
        repeat (3) @(negedge clk);
        check_state("R7 commit low");
        op = 2'd3; operand = 8'h00; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        check_state("R7 reserved op");
        check("R7 reserved no busy", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_reset_mid();
        issue(2'd1, 3'd0, 8'hAA);
        t_reset();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_acc_rotate();
        t_pfx_rotate();
        t_bit_test();
        t_busy_window();
        t_blocked();
        t_ignored();
        t_reset_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule